// File: doc/BRIEF.md
# Write Completion Status Responder

This block is the read side of a byte-wide nonvolatile memory model. An internal programming cycle may be running when the host reads. A read access is open while the active-low chip enable and the active-low output enable are both low. Outside an access the block keeps its data bus released. While the write controller reports that programming is busy, a read of the location written last returns a status word instead of the stored data. In that word, the top polling bit is the inverse of what was written, a toggle bit inverts once per access, and the remaining bits echo the written byte.

When programming ends, reads return the array contents without change, and the toggle bit no longer moves. Host software can therefore poll either bit to learn when the cycle is over. The write controller supplies three inputs: the busy flag, the last written byte and its address. The array data for the current address comes from the storage model. All inputs are sampled on the clock. With the default registered output, the bus shows a result one cycle after the inputs that produced it.

Top module: `prog_status_rdport`

## Requirements
- R1: `bus_oe` is 1 in the cycle after a clock edge that samples both `chip_en_n` and `out_en_n` low. It is 0 in the cycle after an edge that samples either of them high.
- R2: While `bus_oe` is 0, `bus_dout` is 8'h00.
- R3: During a read with `prog_busy` high at `addr == last_wr_addr`, bit 7 of `bus_dout` is the inverse of bit 7 of `last_wr_data`.
- R4: During that same kind of read, bits 5 to 0 of `bus_dout` equal bits 5 to 0 of `last_wr_data`.
- R5: While `prog_busy` is high, bit 6 of the status word inverts exactly once at the start of each read access. An access starts on the first cycle in which both enables are low after a cycle in which one was high, and reads at any address count. Bit 6 stays constant for as long as one access is held open.
- R6: With `prog_busy` low, a read returns `array_rdata` unchanged. Accesses made while `prog_busy` is low do not change the toggle bit, so the first busy read afterwards shows bit 6 inverted only once relative to the last busy read.
- R7: After reset, `bus_oe` is 0 and `bus_dout` is 8'h00.
- R8: During a read with `prog_busy` high at an address other than `last_wr_addr`, `bus_dout` equals `array_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable |
| addr | input | 13 | Read address |
| array_rdata | input | 8 | Stored data at `addr` |
| prog_busy | input | 1 | Programming cycle in progress |
| last_wr_data | input | 8 | Byte most recently written |
| last_wr_addr | input | 13 | Address most recently written |
| bus_dout | output | 8 | Read data, zero when released |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
The main internal state is the toggle register. If it drifts, misses a flip or flips twice, the fault shows up as a bit 6 that fails to alternate between two consecutive busy status reads. That is visible on the second read, one cycle after that access opens. The access edge detector is the other state. If it is wrong, bit 6 changes partway through a held access, or the toggle register moves during idle reads, and the next busy read shows the wrong parity. Select or polarity faults in the output mux appear one cycle after the access starts, as a wrong bit 7, wrong low bits, or array data where the status word belongs.

// File: rtl/nvm_rd_pkg.sv
package nvm_rd_pkg;

   // Source selected for the read bus in a given cycle
   typedef enum logic [1:0] {
      SRC_IDLE   = 2'd0,
      SRC_ARRAY  = 2'd1,
      SRC_STATUS = 2'd2
   } rd_src_e;

endpackage

// File: rtl/rd_access_det.sv
module rd_access_det (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_en_n,
   input  logic out_en_n,
   output logic rd_act,
   output logic rd_start
);
   logic prev_act_q;

   assign rd_act   = ~chip_en_n & ~out_en_n;
   assign rd_start = rd_act & ~prev_act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_act_q <= 1'b0;
      else        prev_act_q <= rd_act;
   end
endmodule

// File: rtl/status_toggle.sv
module status_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_start,
   input  logic prog_busy,
   output logic tog_next
);
   logic tog_q;

   assign tog_next = tog_q ^ (rd_start & prog_busy);

   always_ff @(posedge clk) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= tog_next;
   end
endmodule

// File: rtl/rd_data_mux.sv
module rd_data_mux
   import nvm_rd_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int ADDR_W          = 13,
   parameter int POLL_BIT        = 7,
   parameter int TOGGLE_BIT      = 6,
   parameter bit STATUS_ANY_ADDR = 1'b0
) (
   input  logic              rd_act,
   input  logic              prog_busy,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] last_wr_addr,
   input  logic [DATA_W-1:0] array_rdata,
   input  logic [DATA_W-1:0] last_wr_data,
   input  logic              tog_bit,
   output logic [DATA_W-1:0] data_nxt
);
   rd_src_e           src;
   logic              addr_hit;
   logic [DATA_W-1:0] status_word;
   logic              unused_tog_src;

   assign unused_tog_src = last_wr_data[TOGGLE_BIT];

   generate
      if (STATUS_ANY_ADDR) begin : g_any_addr
         logic [ADDR_W-1:0] unused_addr_pair;
         assign unused_addr_pair = addr ^ last_wr_addr;
         assign addr_hit = 1'b1;
      end else begin : g_match_addr
         assign addr_hit = (addr == last_wr_addr);
      end
   endgenerate

   always_comb begin
      if (!rd_act)                    src = SRC_IDLE;
      else if (prog_busy && addr_hit) src = SRC_STATUS;
      else                            src = SRC_ARRAY;
   end

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         if (i == POLL_BIT)        status_word[i] = ~last_wr_data[i];
         else if (i == TOGGLE_BIT) status_word[i] = tog_bit;
         else                      status_word[i] = last_wr_data[i];
      end
   end

   always_comb begin
      case (src)
         SRC_STATUS: data_nxt = status_word;
         SRC_ARRAY:  data_nxt = array_rdata;
         default:    data_nxt = '0;
      endcase
   end
endmodule

// File: rtl/prog_status_rdport.sv
module prog_status_rdport #(
   parameter int DATA_W          = 8,
   parameter int ADDR_W          = 13,
   parameter int POLL_BIT        = 7,
   parameter int TOGGLE_BIT      = 6,
   parameter bit STATUS_ANY_ADDR = 1'b0,
   parameter bit REG_OUT         = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en_n,
   input  logic              out_en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] array_rdata,
   input  logic              prog_busy,
   input  logic [DATA_W-1:0] last_wr_data,
   input  logic [ADDR_W-1:0] last_wr_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe
);
   // Elaboration-time parameter checks
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (POLL_BIT == TOGGLE_BIT) begin : g_bad_bits
         $error("POLL_BIT and TOGGLE_BIT must differ");
      end
      if (POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W || POLL_BIT < 0 || TOGGLE_BIT < 0) begin : g_bad_pos
         $error("status bit positions must lie inside DATA_W");
      end
   endgenerate

   logic              rd_act;
   logic              rd_start;
   logic              tog_next;
   logic [DATA_W-1:0] data_nxt;

   rd_access_det u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .chip_en_n (chip_en_n),
      .out_en_n  (out_en_n),
      .rd_act    (rd_act),
      .rd_start  (rd_start)
   );

   status_toggle u_tog (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_start  (rd_start),
      .prog_busy (prog_busy),
      .tog_next  (tog_next)
   );

   rd_data_mux #(
      .DATA_W          (DATA_W),
      .ADDR_W          (ADDR_W),
      .POLL_BIT        (POLL_BIT),
      .TOGGLE_BIT      (TOGGLE_BIT),
      .STATUS_ANY_ADDR (STATUS_ANY_ADDR)
   ) u_mux (
      .rd_act       (rd_act),
      .prog_busy    (prog_busy),
      .addr         (addr),
      .last_wr_addr (last_wr_addr),
      .array_rdata  (array_rdata),
      .last_wr_data (last_wr_data),
      .tog_bit      (tog_next),
      .data_nxt     (data_nxt)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         logic              oe_q;
         logic [DATA_W-1:0] dout_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               oe_q   <= 1'b0;
               dout_q <= '0;
            end else begin
               oe_q   <= rd_act;
               dout_q <= data_nxt;
            end
         end
         assign bus_oe   = oe_q;
         assign bus_dout = dout_q;
      end else begin : g_comb_out
         assign bus_oe   = rd_act;
         assign bus_dout = data_nxt;
      end
   endgenerate
endmodule

// File: rtl/nvm_status_rd_chk.sv
module nvm_status_rd_chk #(
   parameter int DATA_W          = 8,
   parameter int ADDR_W          = 13,
   parameter int POLL_BIT        = 7,
   parameter int TOGGLE_BIT      = 6,
   parameter bit STATUS_ANY_ADDR = 1'b0,
   parameter bit REG_OUT         = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en_n,
   input logic              out_en_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] array_rdata,
   input logic              prog_busy,
   input logic [DATA_W-1:0] last_wr_data,
   input logic [ADDR_W-1:0] last_wr_addr,
   input logic [DATA_W-1:0] bus_dout,
   input logic              bus_oe
);
   localparam logic [DATA_W-1:0] LOW_MASK =
      ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT));

   logic rd, stat, hit, stat_q;

   assign rd   = ~chip_en_n & ~out_en_n;
   assign hit  = STATUS_ANY_ADDR ? 1'b1 : (addr == last_wr_addr);
   assign stat = rd & prog_busy & hit;

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= 1'b0;
      else        stat_q <= stat;
   end

   // R2
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_dout == '0));

   generate
      if (REG_OUT) begin : g_reg_props
         // R1
         bus_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd |=> bus_oe);
         // R1
         bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd |=> !bus_oe);
         // R3
         poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stat |=> (bus_dout[POLL_BIT] == ~$past(last_wr_data[POLL_BIT])));
         // R4
         status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stat |=> (((bus_dout ^ $past(last_wr_data)) & LOW_MASK) == '0));
         // R5
         toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stat && stat_q) |=> $stable(bus_dout[TOGGLE_BIT]));
         // R6
         array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && !prog_busy) |=> (bus_dout == $past(array_rdata)));
         // R8
         other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && prog_busy && !hit) |=> (bus_dout == $past(array_rdata)));
      end
   endgenerate
endmodule

bind prog_status_rdport nvm_status_rd_chk #(
   .DATA_W          (DATA_W),
   .ADDR_W          (ADDR_W),
   .POLL_BIT        (POLL_BIT),
   .TOGGLE_BIT      (TOGGLE_BIT),
   .STATUS_ANY_ADDR (STATUS_ANY_ADDR),
   .REG_OUT         (REG_OUT)
) u_chk (.*);

// File: tb/prog_status_rdport_bench.sv
`timescale 1ns/1ps
module prog_status_rdport_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        chip_en_n, out_en_n, prog_busy;
   logic [12:0] addr, last_wr_addr;
   logic [7:0]  array_rdata, last_wr_data;
   logic [7:0]  bus_dout;
   logic        bus_oe;

   int nvec = 0;
   int nmis = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   prog_status_rdport u_prog_status_rdport (
      .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
      .addr(addr), .array_rdata(array_rdata), .prog_busy(prog_busy),
      .last_wr_data(last_wr_data), .last_wr_addr(last_wr_addr),
      .bus_dout(bus_dout), .bus_oe(bus_oe)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nvec++;
      if (act !== exp) begin
         nmis++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Opens an access for 'hold' cycles; returns first sample and whether bit 6 held.
   task automatic rd_access(input logic [12:0] a, input logic [7:0] arr, input int hold,
                            output logic [7:0] d, output bit held6);
      logic [7:0] s;
      addr = a; array_rdata = arr; chip_en_n = 1'b0; out_en_n = 1'b0;
      held6 = 1'b1;
      tick();
      chk("R1 oe on access", {7'd0, bus_oe}, 8'h01);
      d = bus_dout;
      for (int k = 1; k < hold; k++) begin
         tick();
         s = bus_dout;
         if (s[6] !== d[6]) held6 = 1'b0;
      end
      chip_en_n = 1'b1; out_en_n = 1'b1;
      tick();
      chk("R1 oe off after access", {7'd0, bus_oe}, 8'h00);
      chk("R2 released bus zero", bus_dout, 8'h00);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; chip_en_n = 1'b1; out_en_n = 1'b1; prog_busy = 1'b0;
      addr = '0; array_rdata = 8'hFF; last_wr_data = '0; last_wr_addr = '0;
      repeat (3) tick();
      chk("R7 reset oe", {7'd0, bus_oe}, 8'h00);
      chk("R7 reset data", bus_dout, 8'h00);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_idle_reads();
      logic [7:0] d; bit h;
      prog_busy = 1'b0;
      rd_access(13'h0040, 8'hA5, 1, d, h);
      chk("R6 idle read A5", d, 8'hA5);
      rd_access(13'h1FFF, 8'h3C, 3, d, h);
      chk("R6 idle read 3C", d, 8'h3C);
      // only one enable low: no access
      addr = 13'h0040; array_rdata = 8'h77;
      chip_en_n = 1'b0; out_en_n = 1'b1;
      tick();
      chk("R1 CE low OE high no drive", {7'd0, bus_oe}, 8'h00);
      chk("R2 CE low OE high data", bus_dout, 8'h00);
      chip_en_n = 1'b1; out_en_n = 1'b0;
      tick();
      chk("R1 OE low CE high no drive", {7'd0, bus_oe}, 8'h00);
      chk("R2 OE low CE high data", bus_dout, 8'h00);
      out_en_n = 1'b1;
      tick();
   endtask

   task automatic t_busy_poll();
      logic [7:0] d, prev; bit h;
      last_wr_addr = 13'h0123; last_wr_data = 8'h5A; prog_busy = 1'b1;
      tick();
      rd_access(13'h0123, 8'h00, 1, prev, h);
      chk("R3 poll bit inverted (5A)", {7'd0, prev[7]}, 8'h01);
      chk("R4 low bits echo (5A)", {2'b00, prev[5:0]}, 8'h1A);
      for (int n = 0; n < 4; n++) begin
         rd_access(13'h0123, 8'h00, 1, d, h);
         chk("R5 toggle alternates", {7'd0, d[6]}, {7'd0, ~prev[6]});
         chk("R3 poll bit steady", {7'd0, d[7]}, 8'h01);
         prev = d;
      end
      // held access: bit 6 flips once then holds
      rd_access(13'h0123, 8'h00, 4, d, h);
      chk("R5 toggle flips at held access", {7'd0, d[6]}, {7'd0, ~prev[6]});
      chk("R5 toggle stable within access", {7'd0, h}, 8'h01);
      prev = d;
      // different written byte with bit 7 clear
      last_wr_data = 8'h83;
      rd_access(13'h0123, 8'hEE, 1, d, h);
      chk("R3 poll bit inverted (83)", {7'd0, d[7]}, 8'h00);
      chk("R4 low bits echo (83)", {2'b00, d[5:0]}, 8'h03);
      chk("R5 toggle alternates (83)", {7'd0, d[6]}, {7'd0, ~prev[6]});
   endtask

   task automatic t_busy_other();
      logic [7:0] d, prev; bit h;
      last_wr_addr = 13'h0A00; last_wr_data = 8'h2C; prog_busy = 1'b1;
      rd_access(13'h0A00, 8'h00, 1, prev, h);
      rd_access(13'h0A01, 8'h96, 1, d, h);
      chk("R8 other address returns array", d, 8'h96);
      // two starts since prev (other-address read and this one): same parity
      rd_access(13'h0A00, 8'h00, 1, d, h);
      chk("R5 toggle counts other-address access", {7'd0, d[6]}, {7'd0, prev[6]});
      chk("R4 low bits echo (2C)", {2'b00, d[5:0]}, 8'h2C);
   endtask

   task automatic t_done();
      logic [7:0] d, prev; bit h;
      last_wr_addr = 13'h0555; last_wr_data = 8'hC9; prog_busy = 1'b1;
      rd_access(13'h0555, 8'h00, 1, prev, h);
      prog_busy = 1'b0;
      rd_access(13'h0555, 8'hC9, 1, d, h);
      chk("R6 true data after programming", d, 8'hC9);
      rd_access(13'h0555, 8'hC9, 2, d, h);
      chk("R6 true data repeat", d, 8'hC9);
      rd_access(13'h0100, 8'h40, 1, d, h);
      chk("R6 other address after programming", d, 8'h40);
      prog_busy = 1'b1;
      rd_access(13'h0555, 8'h00, 1, d, h);
      chk("R6 no toggling while idle", {7'd0, d[6]}, {7'd0, ~prev[6]});
      prog_busy = 1'b0;
      tick();
   endtask

   initial begin
      t_reset();
      t_idle_reads();
      t_busy_poll();
      t_busy_other();
      t_done();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nmis++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
         $finish;
      end
   end
endmodule